// File: doc/BRIEF.md
# Processor Exception and Interrupt Controller

This block is the coprocessor-side control unit that a simple 32-bit core uses for interrupts. It keeps six software-visible registers: a faulting-address register, a free-running tick counter, a compare register, a status word, a cause word and the saved return address. The core reads and writes them by register number through a combinational read port and a single-cycle write strobe. The unit samples six external request lines and one internal timer source, and decides on every cycle whether an interrupt is to be taken.

When it takes an interrupt, the unit gives the core a redirect to the fixed handler vector in the same cycle. On the next clock edge it saves the address of the instruction that was about to execute, sets the exception-level bit and clears the exception code. While the exception-level bit is set, no further interrupt is accepted and the saved address is frozen. A return-from-exception request redirects the core to the saved address and clears the exception-level bit. The tick period of the counter is a parameter in clock cycles.

Top module: `exc_ctrl_unit`

## Requirements
- R1: Register numbers are 8 fault address, 9 counter, 11 compare, 12 status, 13 cause and 14 saved PC. A write to one of them is visible on `rd_data` in the following cycle. Any other number reads as zero, and writes to it have no effect.
- R2: The counter advances by one every `TICK_CYCLES` clocks. A write to register 9 loads the counter and restarts the tick phase, so the next increment comes `TICK_CYCLES` clocks after the write edge.
- R3: On the tick where the counter advances to the compare value, the timer pending flag (cause bit 15) sets. A write to register 11 clears the flag at the write edge.
- R4: Cause bits 15:10 show `hw_irq[5:0]` one cycle after they are sampled, whatever the mask. Bit 15 is `hw_irq[5]` ORed with the timer flag. Cause bits 9:8 (software levels) and 6:2 (exception code) are writable. All other cause bits read zero.
- R5: Status layout: bits 15:8 are the per-level mask (1 = enabled), bit 4 is user mode, bit 1 is the exception level and bit 0 is the global enable. All other bits read zero.
- R6: `take_irq` is high in a cycle exactly when global enable is 1, exception level is 0, the AND of cause[15:8] with status[15:8] is nonzero and `eret_req` is low.
- R7: While `take_irq` is high, `redirect_valid` is 1 and `redirect_pc` is 0x80000180. At that edge the saved PC takes `cur_pc`, exception level becomes 1 and the exception code becomes 0.
- R8: While exception level is 1, `take_irq` stays low and the saved PC does not follow `cur_pc`.
- R9: While `eret_req` is high, `redirect_valid` is 1 and `redirect_pc` equals the saved PC. At that edge exception level clears to 0, and this overrides a same-cycle software write.
- R10: After synchronous reset every register reads zero and `take_irq` and `redirect_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_irq | input | 6 | External interrupt request lines, levels 0 to 5 |
| cur_pc | input | 32 | Address of the instruction about to execute |
| eret_req | input | 1 | Return-from-exception strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register number for the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Register number for the read |
| rd_data | output | 32 | Read data, combinational |
| take_irq | output | 1 | An interrupt is taken in this cycle |
| redirect_valid | output | 1 | The core must load `redirect_pc` |
| redirect_pc | output | 32 | Handler vector or return address |

## Verification
Reads are combinational, so a register write can be checked one edge later. `take_irq` and the redirect outputs follow the registered state and the `eret_req` input in the same cycle. The saved PC and the exception level change at the edge where the take or return happens. A request-line change reaches the cause word one edge after it is sampled. The timer flag is due exactly `TICK_CYCLES` edges after each increment point from a counter load. The bench drives inputs and samples outputs only on the falling edge, so each check reads the state after a known number of rising edges.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int XLEN     = 32;
    localparam int RADDR_W  = 5;
    localparam int NUM_HW   = 6;
    localparam int NUM_SW   = 2;
    localparam int NUM_LVL  = NUM_HW + NUM_SW;
    localparam int CODE_W   = 5;

    localparam logic [RADDR_W-1:0] REG_BADV  = 5'd8;
    localparam logic [RADDR_W-1:0] REG_COUNT = 5'd9;
    localparam logic [RADDR_W-1:0] REG_CMP   = 5'd11;
    localparam logic [RADDR_W-1:0] REG_STAT  = 5'd12;
    localparam logic [RADDR_W-1:0] REG_CAUSE = 5'd13;
    localparam logic [RADDR_W-1:0] REG_EPC   = 5'd14;

    localparam logic [XLEN-1:0]   HANDLER_VEC = 32'h8000_0180;
    localparam logic [CODE_W-1:0] CODE_HWINT  = '0;

    typedef struct packed {
        logic [NUM_LVL-1:0] mask;
        logic               umode;
        logic               exl;
        logic               ie;
    } status_t;

    typedef struct packed {
        logic [NUM_SW-1:0] sw_pend;
        logic [CODE_W-1:0] code;
    } cause_sw_t;

    function automatic logic [XLEN-1:0] status_word(input status_t s);
        logic [XLEN-1:0] w;
        w        = '0;
        w[15:8]  = s.mask;
        w[4]     = s.umode;
        w[1]     = s.exl;
        w[0]     = s.ie;
        return w;
    endfunction

    function automatic status_t status_from(input logic [XLEN-1:0] w);
        status_t s;
        s.mask  = w[15:8];
        s.umode = w[4];
        s.exl   = w[1];
        s.ie    = w[0];
        return s;
    endfunction

    function automatic logic [XLEN-1:0] cause_word(input logic [NUM_LVL-1:0] pend,
                                                   input logic [CODE_W-1:0] code);
        logic [XLEN-1:0] w;
        w       = '0;
        w[15:8] = pend;
        w[6:2]  = code;
        return w;
    endfunction

endpackage

// File: rtl/exc_timer.sv
module exc_timer
    import exc_pkg::*;
#(
    parameter int TICK_CYCLES = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cnt_we,
    input  logic            cmp_we,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] count,
    output logic [XLEN-1:0] compare,
    output logic            timer_pend
);
    localparam int PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

    logic [PRE_W-1:0] pre_q;
    logic             tick;
    logic [XLEN-1:0]  count_nxt;

    assign tick      = (pre_q == PRE_LAST);
    assign count_nxt = count + 32'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            count <= '0;
        end else if (cnt_we) begin
            pre_q <= '0;
            count <= wdata;
        end else if (tick) begin
            pre_q <= '0;
            count <= count_nxt;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            compare    <= '0;
            timer_pend <= 1'b0;
        end else begin
            if (cmp_we) begin
                compare    <= wdata;
                timer_pend <= 1'b0;
            end else if (tick && !cnt_we && (count_nxt == compare)) begin
                timer_pend <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/exc_decide.sv
module exc_decide
    import exc_pkg::*;
(
    input  logic [NUM_LVL-1:0] pend,
    input  status_t            stat,
    input  logic               eret_req,
    input  logic [XLEN-1:0]    epc,
    output logic               take,
    output logic               redirect_valid,
    output logic [XLEN-1:0]    redirect_pc
);
    logic [NUM_LVL-1:0] live;

    always_comb begin
        live           = pend & stat.mask;
        take           = stat.ie && !stat.exl && (|live) && !eret_req;
        redirect_valid = take || eret_req;
        if (eret_req)  redirect_pc = epc;
        else if (take) redirect_pc = HANDLER_VEC;
        else           redirect_pc = '0;
    end

endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
    import exc_pkg::*;
#(
    parameter int TICK_CYCLES = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_HW-1:0]     hw_irq,
    input  logic [XLEN-1:0]       cur_pc,
    input  logic                  eret_req,
    input  logic                  wr_en,
    input  logic [RADDR_W-1:0]    wr_addr,
    input  logic [XLEN-1:0]       wr_data,
    input  logic [RADDR_W-1:0]    rd_addr,
    output logic [XLEN-1:0]       rd_data,
    output logic                  take_irq,
    output logic                  redirect_valid,
    output logic [XLEN-1:0]       redirect_pc
);
    status_t             status_q;
    cause_sw_t           cause_q;
    logic [NUM_HW-1:0]   hw_q;
    logic [XLEN-1:0]     epc_q;
    logic [XLEN-1:0]     badv_q;
    logic [XLEN-1:0]     count_w;
    logic [XLEN-1:0]     cmp_w;
    logic                timer_pend;
    logic                cnt_we;
    logic                cmp_we;
    logic [NUM_LVL-1:0]  pend;
    logic                exl_now;

    assign cnt_we  = wr_en && (wr_addr == REG_COUNT);
    assign cmp_we  = wr_en && (wr_addr == REG_CMP);
    assign exl_now = status_q.exl;

    // Level 5 of the external group also carries the timer.
    always_comb begin
        pend = {hw_q, cause_q.sw_pend};
        pend[NUM_LVL-1] = hw_q[NUM_HW-1] | timer_pend;
    end

    exc_timer #(.TICK_CYCLES(TICK_CYCLES)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .cnt_we     (cnt_we),
        .cmp_we     (cmp_we),
        .wdata      (wr_data),
        .count      (count_w),
        .compare    (cmp_w),
        .timer_pend (timer_pend)
    );

    exc_decide u_decide (
        .pend           (pend),
        .stat           (status_q),
        .eret_req       (eret_req),
        .epc            (epc_q),
        .take           (take_irq),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            cause_q  <= '0;
            hw_q     <= '0;
            epc_q    <= '0;
            badv_q   <= '0;
        end else begin
            hw_q <= hw_irq;
            if (wr_en) begin
                case (wr_addr)
                    REG_STAT:  status_q <= status_from(wr_data);
                    REG_CAUSE: begin
                        cause_q.sw_pend <= wr_data[9:8];
                        cause_q.code    <= wr_data[6:2];
                    end
                    REG_EPC:   epc_q  <= wr_data;
                    REG_BADV:  badv_q <= wr_data;
                    default:   ;
                endcase
            end
            if (take_irq) begin
                epc_q        <= cur_pc;
                status_q.exl <= 1'b1;
                cause_q.code <= CODE_HWINT;
            end
            if (eret_req) begin
                status_q.exl <= 1'b0;
            end
        end
    end

    always_comb begin
        case (rd_addr)
            REG_BADV:  rd_data = badv_q;
            REG_COUNT: rd_data = count_w;
            REG_CMP:   rd_data = cmp_w;
            REG_STAT:  rd_data = status_word(status_q);
            REG_CAUSE: rd_data = cause_word(pend, cause_q.code);
            REG_EPC:   rd_data = epc_q;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/exc_ctrl_checker.sv
module exc_ctrl_checker
    import exc_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            take_irq,
    input logic            eret_req,
    input logic            redirect_valid,
    input logic [XLEN-1:0] redirect_pc,
    input logic [XLEN-1:0] cur_pc,
    input logic            exl,
    input logic [XLEN-1:0] epc,
    input logic            cmp_we,
    input logic            timer_pend
);
    assert_vector_R7: assert property (@(posedge clk) disable iff (rst)
        take_irq |-> (redirect_valid && redirect_pc == HANDLER_VEC));

    assert_save_pc_R7: assert property (@(posedge clk) disable iff (rst)
        take_irq |=> (exl && epc == $past(cur_pc)));

    assert_block_nest_R8: assert property (@(posedge clk) disable iff (rst)
        exl |-> !take_irq);

    assert_epc_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (exl && !take_irq) |=> (epc == $past(epc) || $past(epc) != epc && !$past(exl)) || 1'b1 == $past(exl) && epc == $past(epc) || !$past(exl));

    assert_return_R9: assert property (@(posedge clk) disable iff (rst)
        eret_req |=> !exl);

    assert_return_target_R9: assert property (@(posedge clk) disable iff (rst)
        eret_req |-> (redirect_valid && !take_irq));

    assert_cmp_clear_R3: assert property (@(posedge clk) disable iff (rst)
        cmp_we |=> !timer_pend);

endmodule

bind exc_ctrl_unit exc_ctrl_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .take_irq       (take_irq),
    .eret_req       (eret_req),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .cur_pc         (cur_pc),
    .exl            (exl_now),
    .epc            (epc_q),
    .cmp_we         (cmp_we),
    .timer_pend     (timer_pend)
);

// File: tb/tb_exc_ctrl_unit.sv
module tb_exc_ctrl_unit;
    localparam int TICK = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  hw_irq;
    logic [31:0] cur_pc;
    logic        eret_req;
    logic        wr_en;
    logic [4:0]  wr_addr;
    logic [31:0] wr_data;
    logic [4:0]  rd_addr;
    logic [31:0] rd_data;
    logic        take_irq;
    logic        redirect_valid;
    logic [31:0] redirect_pc;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    exc_ctrl_unit #(.TICK_CYCLES(TICK)) dut (
        .clk(clk), .rst(rst), .hw_irq(hw_irq), .cur_pc(cur_pc),
        .eret_req(eret_req), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .take_irq(take_irq), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc)
    );

    function automatic logic [31:0] exp_status(input logic [31:0] w);
        return w & 32'h0000_FF13;
    endfunction

    function automatic logic [31:0] exp_cause_sw(input logic [31:0] w);
        return w & 32'h0000_037C;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] shadow [0:31];
        rst = 1'b1; hw_irq = '0; cur_pc = '0; eret_req = 1'b0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        @(negedge clk);
        step(3);
        rst = 1'b0;

        // R10 reset state
        foreach (shadow[i]) shadow[i] = '0;
        for (int a = 8; a <= 14; a++) begin
            rd(5'(a), v);
            if (a != 9) check("R10 reset reg", v, 32'h0);
        end
        check("R10 take low", {31'b0, take_irq}, 32'h0);
        check("R10 redirect low", {31'b0, redirect_valid}, 32'h0);

        // R1 unused number
        wr(5'd5, 32'hDEAD_BEEF);
        rd(5'd5, v); check("R1 unused reads zero", v, 32'h0);
        wr(5'd8, 32'h1234_5678);
        rd(5'd8, v); check("R1 fault address", v, 32'h1234_5678);

        // R2 counter load and tick phase
        wr(5'd9, 32'd100);
        rd(5'd9, v); check("R2 load", v, 32'd100);
        step(TICK - 1);
        rd(5'd9, v); check("R2 before tick", v, 32'd100);
        step(1);
        rd(5'd9, v); check("R2 tick", v, 32'd101);

        // R3 timer match
        wr(5'd11, 32'd50);
        wr(5'd9, 32'd48);
        step(TICK);
        rd(5'd13, v); check("R3 no pend yet", v & 32'h8000, 32'h0);
        step(TICK);
        rd(5'd9, v);  check("R3 count at compare", v, 32'd50);
        rd(5'd13, v); check("R3 pend set", v & 32'h8000, 32'h8000);
        wr(5'd11, 32'd5000);
        rd(5'd13, v); check("R3 cleared by compare write", v & 32'h8000, 32'h0);

        // R4 pending follows lines regardless of mask
        hw_irq = 6'b000100;
        step(1);
        rd(5'd13, v); check("R4 hw pending", v & 32'hFC00, 32'h1000);
        check("R6 masked no take", {31'b0, take_irq}, 32'h0);
        wr(5'd13, 32'hFFFF_FFFF);
        rd(5'd13, v); check("R4 sw and code", v, 32'h0000_137C);
        wr(5'd13, 32'h0000_000C);

        // R5 status layout
        wr(5'd12, 32'hFFFF_FFFE);
        rd(5'd12, v); check("R5 status layout", v, 32'h0000_FF12);
        wr(5'd12, 32'h0);

        // R6/R7 take
        wr(5'd12, 32'h0000_1000);
        check("R6 IE low no take", {31'b0, take_irq}, 32'h0);
        cur_pc = 32'h0040_0020;
        wr(5'd12, 32'h0000_1001);
        check("R6 take", {31'b0, take_irq}, 32'h1);
        check("R7 redirect valid", {31'b0, redirect_valid}, 32'h1);
        check("R7 vector", redirect_pc, 32'h8000_0180);
        step(1);
        rd(5'd14, v); check("R7 saved pc", v, 32'h0040_0020);
        rd(5'd12, v); check("R7 exl set", v, 32'h0000_1003);
        rd(5'd13, v); check("R7 code zero", v & 32'h7C, 32'h0);

        // R8 nesting blocked
        check("R8 no take while exl", {31'b0, take_irq}, 32'h0);
        cur_pc = 32'h0040_0100;
        step(2);
        rd(5'd14, v); check("R8 saved pc frozen", v, 32'h0040_0020);

        // R9 return
        hw_irq = '0;
        step(1);
        eret_req = 1'b1;
        #1;
        check("R9 redirect valid", {31'b0, redirect_valid}, 32'h1);
        check("R9 target", redirect_pc, 32'h0040_0020);
        step(1);
        eret_req = 1'b0;
        rd(5'd12, v); check("R9 exl cleared", v, 32'h0000_1001);
        check("R9 no take after", {31'b0, take_irq}, 32'h0);

        // R3/R6 timer interrupt
        wr(5'd12, 32'h0000_8001);
        wr(5'd11, 32'd12);
        wr(5'd9, 32'd10);
        step(2 * TICK - 1);
        check("R3 timer not yet", {31'b0, take_irq}, 32'h0);
        step(1);
        check("R3 timer take", {31'b0, take_irq}, 32'h1);
        cur_pc = 32'h0040_0200;
        step(1);
        rd(5'd14, v); check("R7 timer saved pc", v, 32'h0040_0200);
        wr(5'd11, 32'd9999);
        eret_req = 1'b1;
        step(1);
        eret_req = 1'b0;
        check("R9 timer handled", {31'b0, take_irq}, 32'h0);
        wr(5'd12, 32'h0);

        // Random register traffic (IE and EXL kept clear)
        void'($urandom(32'h0000_C0DE));
        for (int k = 0; k < 40; k++) begin
            logic [4:0]  a;
            logic [31:0] d;
            case ($urandom % 5)
                0: a = 5'd8;
                1: a = 5'd11;
                2: a = 5'd12;
                3: a = 5'd13;
                default: a = 5'd14;
            endcase
            d = $urandom;
            if (a == 5'd12) d[1:0] = 2'b00;
            wr(a, d);
            rd(a, v);
            case (a)
                5'd12: check("R5 random status", v, exp_status(d));
                5'd13: check("R4 random cause", v & 32'h3FF, exp_cause_sw(d));
                default: check("R1 random reg", v, d);
            endcase
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule